// File: doc/BRIEF.md
# Protocol Discovery Responder

This block answers protocol-discovery queries on behalf of a mailbox controller. The controller pulses `start` and supplies the type code of the pending request. For a discovery request, the responder reads the request's length dword and index dword from the controller's request buffer. It then looks up the indexed entry in a small table of supported (vendor ID, type) pairs and writes a three-dword response object into the response buffer. When it is finished it returns `done` for one cycle, qualified by `discard`, `error` and a response length.

Table entries 0 and 1 are fixed: the discovery protocol itself and a second built-in protocol. Further entries are set by parameters at elaboration. Each response also carries the index of the next entry, and that index wraps to zero after the last entry, so host software can walk the whole table by feeding back the returned index. A request of the second built-in type is not served: the block reports an error and asks the controller to clear its buffers.

Top module: `disc_responder`

## Requirements
- R1: For a start with type 0x00 and a request length (bits 17:0 of request dword 1) of 3 or more, the block writes response dwords at addresses 0, 1 and 2. Dword 0 is 0x00000001, which holds vendor 0x0001 in bits 15:0 and type 0x00 in bits 23:16. Dword 1 is 0x00000003, the length.
- R2: Response dword 2 carries the vendor ID of the table entry selected by request dword 2 bits 7:0, in bits 15:0, and its type in bits 23:16. Entry 0 is (0x0001, 0x00), entry 1 is (0x0001, 0x01), and entries from 2 up come from the parameter list (defaults (0x1E98, 0x02) and (0x1ABC, 0x05)).
- R3: An index at or above the entry count (default 4) returns vendor 0xFFFF and type 0xFF.
- R4: Bits 31:24 of response dword 2 hold index+1 when that is below the entry count, and 0 otherwise.
- R5: A discovery request with a length below 3 is discarded: there are no response writes and no error. Bits 31:18 of dword 1 and bits 31:8 of dword 2 have no effect.
- R6: A start with type 0x01 produces no writes and finishes with `discard`, `error` and `clearBufs` all high in the `done` cycle.
- R7: A start with any type other than 0x00 or 0x01 finishes with `discard` high and `error` low, and produces no writes.
- R8: `done` is a one-cycle pulse. It comes 6 cycles after the start cycle for a served request, exactly one cycle after the last response write. It comes 2 cycles after the start cycle for a short-length discard and 1 cycle after it for the type 0x01 and unknown-type paths.
- R9: `rspLen` equals 3 in a `done` cycle without discard, and 0 in a `done` cycle with discard.
- R10: `start` is ignored while a request is in progress. Such a start produces no second `done` and does not alter the response.
- R11: During and right after reset, `done`, `discard`, `error`, `clearBufs` and `rspWrEn` are low, and `rspLen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin processing the pending request |
| reqType | input | 8 | Type code of the pending request |
| reqRdAddr | output | 2 | Dword address into the request buffer |
| reqRdData | input | 32 | Request buffer data at `reqRdAddr` (same cycle) |
| rspWrEn | output | 1 | Response buffer write strobe |
| rspWrAddr | output | 2 | Response buffer dword address |
| rspWrData | output | 32 | Response buffer write data |
| done | output | 1 | One-cycle completion pulse |
| discard | output | 1 | With `done`: no response was produced |
| error | output | 1 | With `done`: error status for the controller |
| clearBufs | output | 1 | With `done`: controller must clear its response buffer and request length |
| rspLen | output | 18 | With `done`: response length in dwords |

## Verification
If the sequencer state is wrong, it shows up at once as a misplaced write strobe or as a `done` pulse that comes early, comes late, or comes twice. The bench therefore times every completion against the start cycle and against the last write. A wrong captured index or a wrong table word shows up only in response dword 2. For that reason the vectors cover every table entry, the first index past the end, the maximum index, and requests whose reserved bits are set. A wrong length decision appears within two cycles as a missing or extra discard.

// File: rtl/disc_pkg.sv
package disc_pkg;

  localparam int unsigned LEN_W = 18;
  localparam logic [15:0] STD_VENDOR  = 16'h0001;
  localparam logic [7:0]  TYPE_DISC   = 8'h00;
  localparam logic [7:0]  TYPE_SECOND = 8'h01;
  localparam logic [LEN_W-1:0] RSP_DWORDS = 18'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDLEN,
    ST_RDIDX,
    ST_WR0,
    ST_WR1,
    ST_WR2,
    ST_FIN
  } discState_t;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic       rdLen;
    logic       capIdx;
    logic       wrEn;
    logic [1:0] wordSel;
  } dpStrobe_t;

endpackage

// File: rtl/disc_table.sv
module disc_table #(
  parameter int unsigned EXTRA_NUM = 2,
  parameter logic [((EXTRA_NUM > 0) ? EXTRA_NUM : 1)*24-1:0] EXTRA_ENTRIES =
    {24'h05_1ABC, 24'h02_1E98}
) (
  input  logic [7:0]  idx,
  output logic [23:0] entry,
  output logic [7:0]  nextIdx
);
  import disc_pkg::*;

  localparam int unsigned PROTO_COUNT = 2 + EXTRA_NUM;
  localparam logic [9:0]  COUNT10     = 10'(PROTO_COUNT);

  logic [23:0] tbl [PROTO_COUNT];

  for (genvar gi = 0; gi < PROTO_COUNT; gi++) begin : g_entry
    if (gi == 0) begin : g_disc
      assign tbl[gi] = {TYPE_DISC, STD_VENDOR};
    end else if (gi == 1) begin : g_second
      assign tbl[gi] = {TYPE_SECOND, STD_VENDOR};
    end else begin : g_extra
      assign tbl[gi] = EXTRA_ENTRIES[(gi-2)*24 +: 24];
    end
  end

  always_comb begin
    entry = 24'hFF_FFFF;
    for (int i = 0; i < PROTO_COUNT; i++) begin
      if (idx == 8'(i)) entry = tbl[i];
    end
  end

  logic [9:0] succ;
  assign succ    = {2'b00, idx} + 10'd1;
  assign nextIdx = (succ < COUNT10) ? succ[7:0] : 8'h00;

endmodule

// File: rtl/disc_ctrl.sv
module disc_ctrl
  import disc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       reqType,
  input  logic             lenShort,
  output dpStrobe_t        strb,
  output logic             done,
  output logic             discard,
  output logic             error,
  output logic             clearBufs,
  output logic [LEN_W-1:0] rspLen
);

  discState_t state, stateN;
  logic discReg, discN, errReg, errN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      discReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      state   <= stateN;
      discReg <= discN;
      errReg  <= errN;
    end
  end

  always_comb begin
    stateN = state;
    discN  = discReg;
    errN   = errReg;
    unique case (state)
      ST_IDLE: if (start) begin
        if (reqType == TYPE_DISC) begin
          stateN = ST_RDLEN;
        end else begin
          stateN = ST_FIN;
          discN  = 1'b1;
          errN   = (reqType == TYPE_SECOND);
        end
      end
      ST_RDLEN: begin
        stateN = lenShort ? ST_FIN : ST_RDIDX;
        discN  = lenShort;
        errN   = 1'b0;
      end
      ST_RDIDX: stateN = ST_WR0;
      ST_WR0:   stateN = ST_WR1;
      ST_WR1:   stateN = ST_WR2;
      ST_WR2:   stateN = ST_FIN;
      ST_FIN:   stateN = ST_IDLE;
      default:  stateN = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.rdLen   = (state == ST_RDLEN);
    strb.capIdx  = (state == ST_RDIDX);
    strb.wrEn    = (state == ST_WR0) || (state == ST_WR1) || (state == ST_WR2);
    strb.wordSel = (state == ST_WR1) ? 2'd1 : ((state == ST_WR2) ? 2'd2 : 2'd0);
  end

  assign done      = (state == ST_FIN);
  assign discard   = done && discReg;
  assign error     = done && errReg;
  assign clearBufs = error;
  assign rspLen    = (done && !discReg) ? RSP_DWORDS : '0;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !discard) |-> ($past(strb.wrEn) && $past(strb.wordSel) == 2'd2));

  // R6
  err_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (discard && clearBufs));

  // R9
  len_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !discard) |-> (rspLen == RSP_DWORDS));

endmodule

// File: rtl/disc_datapath.sv
module disc_datapath
  import disc_pkg::*;
#(
  parameter int unsigned EXTRA_NUM = 2,
  parameter logic [((EXTRA_NUM > 0) ? EXTRA_NUM : 1)*24-1:0] EXTRA_ENTRIES =
    {24'h05_1ABC, 24'h02_1E98}
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [31:0] reqRdData,
  output logic [1:0]  reqRdAddr,
  output logic        lenShort,
  output logic        rspWrEn,
  output logic [1:0]  rspWrAddr,
  output logic [31:0] rspWrData
);

  localparam logic [8:0] COUNT9 = 9'(2 + EXTRA_NUM);

  logic [7:0]  idxReg;
  logic [23:0] entry;
  logic [7:0]  nextIdx;
  logic        unusedReqBits;

  // Reserved request bits are never used
  assign unusedReqBits = ^{reqRdData[31:18]};

  assign reqRdAddr = strb.capIdx ? 2'd2 : 2'd1;
  assign lenShort  = reqRdData[LEN_W-1:0] < RSP_DWORDS;

  always_ff @(posedge clk) begin
    if (!rstN) idxReg <= 8'h00;
    else if (strb.capIdx) idxReg <= reqRdData[7:0];
  end

  disc_table #(
    .EXTRA_NUM    (EXTRA_NUM),
    .EXTRA_ENTRIES(EXTRA_ENTRIES)
  ) u_table (
    .idx    (idxReg),
    .entry  (entry),
    .nextIdx(nextIdx)
  );

  assign rspWrEn   = strb.wrEn;
  assign rspWrAddr = strb.wordSel;

  always_comb begin
    unique case (strb.wordSel)
      2'd0:    rspWrData = {8'h00, TYPE_DISC, STD_VENDOR};
      2'd1:    rspWrData = {14'h0, RSP_DWORDS};
      default: rspWrData = {nextIdx, entry};
    endcase
  end

  // R3
  oor_sentinel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wordSel == 2'd2 && {1'b0, idxReg} >= COUNT9)
      |-> (rspWrData[23:0] == 24'hFF_FFFF));

  // R4
  next_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wordSel == 2'd2) |-> ({1'b0, rspWrData[31:24]} < COUNT9));

endmodule

// File: rtl/disc_responder.sv
module disc_responder
  import disc_pkg::*;
#(
  parameter int unsigned EXTRA_NUM = 2,
  parameter logic [((EXTRA_NUM > 0) ? EXTRA_NUM : 1)*24-1:0] EXTRA_ENTRIES =
    {24'h05_1ABC, 24'h02_1E98}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  reqType,
  output logic [1:0]  reqRdAddr,
  input  logic [31:0] reqRdData,
  output logic        rspWrEn,
  output logic [1:0]  rspWrAddr,
  output logic [31:0] rspWrData,
  output logic        done,
  output logic        discard,
  output logic        error,
  output logic        clearBufs,
  output logic [17:0] rspLen
);

  dpStrobe_t strb;
  logic      lenShort;

  disc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqType  (reqType),
    .lenShort (lenShort),
    .strb     (strb),
    .done     (done),
    .discard  (discard),
    .error    (error),
    .clearBufs(clearBufs),
    .rspLen   (rspLen)
  );

  disc_datapath #(
    .EXTRA_NUM    (EXTRA_NUM),
    .EXTRA_ENTRIES(EXTRA_ENTRIES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqRdData(reqRdData),
    .reqRdAddr(reqRdAddr),
    .lenShort (lenShort),
    .rspWrEn  (rspWrEn),
    .rspWrAddr(rspWrAddr),
    .rspWrData(rspWrData)
  );

endmodule

// File: tb/disc_responder_bench.sv
`timescale 1ns/1ps
module disc_responder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  reqType = 8'h00;
  logic [1:0]  reqRdAddr;
  logic [31:0] reqRdData;
  logic        rspWrEn;
  logic [1:0]  rspWrAddr;
  logic [31:0] rspWrData;
  logic        done, discard, error, clearBufs;
  logic [17:0] rspLen;

  logic [31:0] reqMem [4];
  assign reqRdData = reqMem[reqRdAddr];

  disc_responder u_disc_responder (
    .clk(clk), .rstN(rstN), .start(start), .reqType(reqType),
    .reqRdAddr(reqRdAddr), .reqRdData(reqRdData),
    .rspWrEn(rspWrEn), .rspWrAddr(rspWrAddr), .rspWrData(rspWrData),
    .done(done), .discard(discard), .error(error), .clearBufs(clearBufs),
    .rspLen(rspLen)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycleNum = 0;
  int wrCount = 0, lastWrCyc = 0;
  int doneCnt = 0, doneCyc = 0;
  logic doneDisc = 0, doneErr = 0, doneClr = 0;
  logic [17:0] doneLen = '0;
  logic [31:0] rspCap [4];

  always @(posedge clk) begin
    if (rspWrEn) begin
      rspCap[rspWrAddr] <= rspWrData;
      wrCount   <= wrCount + 1;
      lastWrCyc <= cycleNum;
    end
    if (done) begin
      doneCnt  <= doneCnt + 1;
      doneCyc  <= cycleNum;
      doneDisc <= discard;
      doneErr  <= error;
      doneClr  <= clearBufs;
      doneLen  <= rspLen;
    end
    cycleNum <= cycleNum + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // {type[8], dw1[32], dw2[32], expDiscard, expError, expWord2[32]}
  localparam logic [105:0] VECS [13] = '{
    {8'h00, 32'h0000_0003, 32'h0000_0000, 1'b0, 1'b0, 32'h0100_0001}, // R1 R2 R4 entry 0
    {8'h00, 32'h0000_0003, 32'h0000_0001, 1'b0, 1'b0, 32'h0201_0001}, // R2 entry 1
    {8'h00, 32'h0000_0003, 32'h0000_0002, 1'b0, 1'b0, 32'h0302_1E98}, // R2 entry 2
    {8'h00, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0, 32'h0005_1ABC}, // R4 last wraps
    {8'h00, 32'h0000_0003, 32'h0000_0004, 1'b0, 1'b0, 32'h00FF_FFFF}, // R3 first past end
    {8'h00, 32'h0000_0003, 32'h0000_00FF, 1'b0, 1'b0, 32'h00FF_FFFF}, // R3 max index
    {8'h00, 32'h0000_0002, 32'h0000_0000, 1'b1, 1'b0, 32'h0},         // R5 short
    {8'h00, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 32'h0},         // R5 zero length
    {8'h00, 32'h0000_0005, 32'hABCD_EF01, 1'b0, 1'b0, 32'h0201_0001}, // R5 reserved idx bits
    {8'h00, 32'hFFFC_0002, 32'h0000_0000, 1'b1, 1'b0, 32'h0},         // R5 upper len bits
    {8'h00, 32'h0004_0003, 32'hFFFF_FF02, 1'b0, 1'b0, 32'h0302_1E98}, // R5 upper bits ignored
    {8'h01, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b1, 32'h0},         // R6 second type
    {8'h07, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b0, 32'h0}          // R7 unknown type
  };

  task automatic waitDone(input int base);
    for (int w = 0; w < 50 && doneCnt == base; w++) @(negedge clk);
    if (doneCnt == base) check("R8 done timeout", 32'(doneCnt), 32'(base + 1));
  endtask

  task automatic runVec(input logic [105:0] v);
    logic [7:0]  t;
    logic        expDisc, expErr;
    logic [31:0] expW2;
    int wrBase, doneBase, startCyc, expLat;
    t = v[105:98];
    expDisc = v[33];
    expErr = v[32];
    expW2 = v[31:0];
    reqMem[0] = {8'h00, t, 16'h0001};
    reqMem[1] = v[97:66];
    reqMem[2] = v[65:34];
    reqMem[3] = 32'h0;
    @(negedge clk);
    wrBase = wrCount;
    doneBase = doneCnt;
    startCyc = cycleNum;
    start = 1'b1;
    reqType = t;
    @(negedge clk);
    start = 1'b0;
    waitDone(doneBase);
    expLat = (t != 8'h00) ? 1 : (expDisc ? 2 : 6);
    check("R8 latency", 32'(doneCyc - startCyc), 32'(expLat));
    check("R5/R7 discard", {31'h0, doneDisc}, {31'h0, expDisc});
    check("R6/R7 error", {31'h0, doneErr}, {31'h0, expErr});
    check("R6 clearBufs", {31'h0, doneClr}, {31'h0, expErr});
    check("R9 rspLen", {14'h0, doneLen}, expDisc ? 32'h0 : 32'h3);
    check("R1/R5 write count", 32'(wrCount - wrBase), expDisc ? 32'h0 : 32'h3);
    if (!expDisc) begin
      check("R1 word0", rspCap[0], 32'h0000_0001);
      check("R1 word1", rspCap[1], 32'h0000_0003);
      check("R2/R3/R4 word2", rspCap[2], expW2);
      check("R8 done after last write", 32'(doneCyc - lastWrCyc), 32'h1);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int doneBase, wrBase;
    for (int i = 0; i < 4; i++) reqMem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", {31'h0, done}, 32'h0);
    check("R11 discard", {31'h0, discard}, 32'h0);
    check("R11 error", {31'h0, error}, 32'h0);
    check("R11 clearBufs", {31'h0, clearBufs}, 32'h0);
    check("R11 rspWrEn", {31'h0, rspWrEn}, 32'h0);
    check("R11 rspLen", {14'h0, rspLen}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < 13; n++) runVec(VECS[n]);

    // R10: second start while busy is ignored
    reqMem[1] = 32'h3;
    reqMem[2] = 32'h1;
    @(negedge clk);
    doneBase = doneCnt;
    wrBase = wrCount;
    start = 1'b1;
    reqType = 8'h00;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    reqType = 8'h01;
    @(negedge clk);
    start = 1'b0;
    reqType = 8'h00;
    waitDone(doneBase);
    repeat (12) @(negedge clk);
    check("R10 single done", 32'(doneCnt - doneBase), 32'h1);
    check("R10 no error", {31'h0, doneErr}, 32'h0);
    check("R10 writes", 32'(wrCount - wrBase), 32'h3);
    check("R10 word2", rspCap[2], 32'h0201_0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule